// File: doc/BRIEF.md
# Chained DMA Channel Interrupt Controller

This block keeps the run state, the remaining word count and the interrupt latches for a small set of DMA channels. Software starts a channel by writing a word count and a chain pointer through a simple register port. The datapath then pulses a per-channel strobe for each word it moves, and the block counts the words down. A channel runs either a single block or a linked series of blocks. When a block in a series ends, the block asks for the next descriptor and waits until it arrives.

A control bit at position 19 of each chain pointer chooses when a chained channel raises its interrupt. With the bit set, the channel interrupts at the end of every block. With the bit clear, it interrupts only when the whole series ends. A pointer whose address field is zero marks the last block. A strobe on an idle channel stands for a single-word access to that channel's buffer, and it also raises the interrupt. The latches stay set until software clears them, and they are ORed into one request line.

Top module: `dma_chain_irq_ctrl`

## Requirements
- R1: A write to address c (0 ≤ c < NCH) that has the enable bit set (data bit CW+PW, bit 36 by default) starts channel c when it is idle. The count is taken from data bits [CW-1:0] and the pointer from bits [CW+PW-1:CW]. The channel's active bit reads 1 from the next cycle, and reading address 2+c returns the loaded count.
- R2: Each strobe on a running channel whose count is above one lowers the count by one.
- R3: Take a running block whose pointer address field (all pointer bits except bit 19) is zero. On the edge where its count reaches zero, its interrupt latch sets and its active bit clears.
- R4: Take a block whose pointer has a nonzero address field and has bit 19 set. On the edge where that block completes, its interrupt latch sets and the channel starts a descriptor request. desc_req goes to 1, desc_addr carries the pointer with bit 19 cleared, and the active bit stays 1.
- R5: A block whose pointer has a nonzero address field and has bit 19 clear completes without setting the latch. The chain interrupts only at its final block.
- R6: While desc_req is 1, the channel holds its count and stays active until desc_valid arrives. On that edge it loads desc_count and desc_ptr and runs again.
- R7: A strobe on an idle channel sets that channel's interrupt latch.
- R8: Latch bits stay set until a write to address NCH (4 by default) with a 1 in the matching data bit [NCH-1:0] clears them. A latch event in the same cycle as the clear leaves the bit set.
- R9: A start write with a count of zero sets the active bit for one cycle. The latch sets on the following edge and the channel returns to idle.
- R10: A start write to an active channel changes nothing. A write to a channel address with the enable bit clear changes nothing.
- R11: irq is 1 exactly while any bit of irq_vec is 1. irq_vec shows the latch bits.
- R12: Reading address 0 returns the active bits, address 1 returns the latch bits, and address 2+c returns channel c's count. All other data bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: channel start or latch clear |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| buf_strb | input | NCH | Per-channel word-transfer or buffer-access strobe |
| desc_req | output | NCH | Channel waiting for its next descriptor |
| desc_addr | output | NCH*PW | Address field of each channel's current pointer |
| desc_valid | input | NCH | Descriptor presented for the channel |
| desc_count | input | NCH*CW | Next block count per channel |
| desc_ptr | input | NCH*PW | Next chain pointer per channel |
| irq_vec | output | NCH | Interrupt latch bits |
| irq | output | 1 | OR of all latch bits |

## Verification
Several rules are checked by assertions on every cycle. These are the one-step count decrement, the drop to idle after a final block, the hold during a descriptor wait, the entry into the fetch state, and the set-wins, clear and sticky behaviour of the latches. Other behaviour needs a bench scenario to show it. That covers whether bit 19 suppresses or raises an interrupt across a whole chain, and the one-cycle active window of a zero-count start. It also covers ignored writes to busy or disabled channels and the read map. The bench compares all of these against a cycle model under random traffic and in directed sequences.

// File: rtl/dci_pkg.sv
package dci_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_RUN   = 2'd1,
      CH_FETCH = 2'd2
   } ch_state_e;
endpackage

// File: rtl/dci_channel.sv
module dci_channel
   import dci_pkg::*;
#(
   parameter int CW      = 16,
   parameter int PW      = 20,
   parameter int PCI_BIT = 19
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] st_count,
   input  logic [PW-1:0] st_ptr,
   input  logic          strb,
   input  logic          desc_valid,
   input  logic [CW-1:0] desc_count,
   input  logic [PW-1:0] desc_ptr,
   output logic          active,
   output logic [CW-1:0] count,
   output logic          ev,
   output logic          desc_req,
   output logic [PW-1:0] desc_addr
);
   localparam logic [PW-1:0] FLAG_MASK = {{(PW-1){1'b0}}, 1'b1} << PCI_BIT;
   localparam logic [PW-1:0] ADDR_MASK = ~FLAG_MASK;

   ch_state_e     state;
   logic [CW-1:0] cnt;
   logic [PW-1:0] ptr;
   logic          last_blk, pci, done;

   assign last_blk  = (ptr & ADDR_MASK) == '0;
   assign pci       = ptr[PCI_BIT];
   assign done      = (state == CH_RUN) && ((cnt == '0) || ((cnt == CW'(1)) && strb));
   assign ev        = ((state == CH_IDLE) && strb) || (done && (last_blk || pci));
   assign active    = state != CH_IDLE;
   assign count     = cnt;
   assign desc_req  = state == CH_FETCH;
   assign desc_addr = ptr & ADDR_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CH_IDLE;
         cnt   <= '0;
         ptr   <= '0;
      end else begin
         case (state)
            CH_IDLE: if (start) begin
               cnt   <= st_count;
               ptr   <= st_ptr;
               state <= CH_RUN;
            end
            CH_RUN: if (done) begin
               cnt   <= '0;
               state <= last_blk ? CH_IDLE : CH_FETCH;
            end else if (strb) begin
               cnt <= cnt - CW'(1);
            end
            CH_FETCH: if (desc_valid) begin
               cnt   <= desc_count;
               ptr   <= desc_ptr;
               state <= CH_RUN;
            end
            default: state <= CH_IDLE;
         endcase
      end
   end

   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CH_RUN && strb && cnt > CW'(1)) |=> (count == $past(count) - CW'(1)));

   assert_final_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && last_blk) |=> !active);

   assert_enter_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !last_blk) |=> (desc_req && active));

   assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_req && !desc_valid) |=> (desc_req && active && $stable(count)));
endmodule

// File: rtl/dci_latch.sv
module dci_latch #(
   parameter int NCH = 4
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set,
   input  logic [NCH-1:0] clr,
   output logic [NCH-1:0] lat,
   output logic           irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) lat <= '0;
      else        lat <= (lat & ~clr) | set;
   end

   assign irq = |lat;

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((lat & $past(set)) == $past(set)));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~set)) |=> ((lat & $past(clr & ~set)) == '0));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|lat) |=> ((($past(lat) & ~$past(clr)) & ~lat) == '0));
endmodule

// File: rtl/dma_chain_irq_ctrl.sv
module dma_chain_irq_ctrl #(
   parameter int NCH     = 4,
   parameter int CW      = 16,
   parameter int PW      = 20,
   parameter int PCI_BIT = 19,
   parameter int AW      = $clog2(NCH + 2),
   parameter int DW      = CW + PW + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic [NCH-1:0]    buf_strb,
   output logic [NCH-1:0]    desc_req,
   output logic [NCH*PW-1:0] desc_addr,
   input  logic [NCH-1:0]    desc_valid,
   input  logic [NCH*CW-1:0] desc_count,
   input  logic [NCH*PW-1:0] desc_ptr,
   output logic [NCH-1:0]    irq_vec,
   output logic              irq
);
   localparam int EN_BIT  = CW + PW;
   localparam int CLR_ADR = NCH;

   initial begin
      assert (PCI_BIT >= 0 && PCI_BIT < PW) else $error("PCI_BIT outside pointer");
      assert (DW == CW + PW + 1) else $error("DW must equal CW+PW+1");
      assert (AW >= $clog2(NCH + 2)) else $error("AW too narrow");
      assert (NCH >= 1 && NCH <= DW) else $error("NCH out of range");
   end

   logic [NCH-1:0] start_v, active_v, ev_v, clr_v;
   logic [CW-1:0]  cnt_v [NCH];

   assign clr_v = (wr_en && wr_addr == AW'(CLR_ADR)) ? wr_data[NCH-1:0] : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign start_v[i] = wr_en && (wr_addr == AW'(i)) && wr_data[EN_BIT];
      dci_channel #(.CW(CW), .PW(PW), .PCI_BIT(PCI_BIT)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (start_v[i]),
         .st_count   (wr_data[CW-1:0]),
         .st_ptr     (wr_data[CW+PW-1:CW]),
         .strb       (buf_strb[i]),
         .desc_valid (desc_valid[i]),
         .desc_count (desc_count[i*CW +: CW]),
         .desc_ptr   (desc_ptr[i*PW +: PW]),
         .active     (active_v[i]),
         .count      (cnt_v[i]),
         .ev         (ev_v[i]),
         .desc_req   (desc_req[i]),
         .desc_addr  (desc_addr[i*PW +: PW])
      );
   end

   dci_latch #(.NCH(NCH)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_v),
      .clr   (clr_v),
      .lat   (irq_vec),
      .irq   (irq)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(0))      rd_data[NCH-1:0] = active_v;
      else if (rd_addr == AW'(1)) rd_data[NCH-1:0] = irq_vec;
      else begin
         for (int c = 0; c < NCH; c++)
            if (rd_addr == AW'(c + 2)) rd_data[CW-1:0] = cnt_v[c];
      end
   end
endmodule

// File: tb/sim_dma_chain_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chain_irq_ctrl;
   localparam int NCH = 4, CW = 16, PW = 20, PCI_BIT = 19;
   localparam int AW = $clog2(NCH + 2), DW = CW + PW + 1;
   localparam logic [PW-1:0] FLAG = {{(PW-1){1'b0}}, 1'b1} << PCI_BIT;
   localparam logic [PW-1:0] AMASK = ~FLAG;

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic [NCH-1:0] buf_strb = '0, desc_req, desc_valid = '0, irq_vec;
   logic [NCH*PW-1:0] desc_addr, desc_ptr = '0;
   logic [NCH*CW-1:0] desc_count = '0;
   logic irq;

   int n_chk = 0, n_err = 0, cyc_n = 0;

   always #2 clk = ~clk;

   dma_chain_irq_ctrl #(.NCH(NCH), .CW(CW), .PW(PW), .PCI_BIT(PCI_BIT)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .buf_strb(buf_strb), .desc_req(desc_req),
      .desc_addr(desc_addr), .desc_valid(desc_valid), .desc_count(desc_count),
      .desc_ptr(desc_ptr), .irq_vec(irq_vec), .irq(irq));

   // cycle model built from the requirements
   int            m_st  [NCH];
   logic [CW-1:0] m_cnt [NCH];
   logic [PW-1:0] m_ptr [NCH];
   logic [NCH-1:0] m_lat;

   always @(posedge clk) begin : model
      logic [NCH-1:0] ev;
      logic fin;
      ev = '0;
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin m_st[i] = 0; m_cnt[i] = '0; m_ptr[i] = '0; end
         m_lat = '0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            case (m_st[i])
               0: begin
                  if (buf_strb[i]) ev[i] = 1'b1;
                  if (wr_en && wr_addr == AW'(i) && wr_data[DW-1]) begin
                     m_cnt[i] = wr_data[CW-1:0];
                     m_ptr[i] = wr_data[CW+PW-1:CW];
                     m_st[i]  = 1;
                  end
               end
               1: begin
                  if (m_cnt[i] == 0 || (m_cnt[i] == 1 && buf_strb[i])) begin
                     fin = (m_ptr[i] & AMASK) == '0;
                     if (fin || m_ptr[i][PCI_BIT]) ev[i] = 1'b1;
                     m_st[i]  = fin ? 0 : 2;
                     m_cnt[i] = '0;
                  end else if (buf_strb[i]) m_cnt[i] = m_cnt[i] - 1'b1;
               end
               default: if (desc_valid[i]) begin
                  m_cnt[i] = desc_count[i*CW +: CW];
                  m_ptr[i] = desc_ptr[i*PW +: PW];
                  m_st[i]  = 1;
               end
            endcase
         end
         if (wr_en && wr_addr == AW'(NCH)) m_lat = m_lat & ~wr_data[NCH-1:0];
         m_lat = m_lat | ev;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   function automatic logic [NCH-1:0] m_active();
      for (int i = 0; i < NCH; i++) m_active[i] = (m_st[i] != 0);
   endfunction

   task automatic model_cmp();
      chk("R8 latch vector", 64'(irq_vec), 64'(m_lat));
      chk("R11 irq line", 64'(irq), 64'(|m_lat));
      for (int i = 0; i < NCH; i++) begin
         chk("R6 desc_req", 64'(desc_req[i]), 64'(m_st[i] == 2));
         if (m_st[i] == 2) chk("R6 desc_addr", 64'(desc_addr[i*PW +: PW]), 64'(m_ptr[i] & AMASK));
      end
      if (rd_addr == '0) chk("R1 active bits", 64'(rd_data), 64'(m_active()));
   endtask

   task automatic cyc();
      @(negedge clk);
      model_cmp();
      wr_en = 0; buf_strb = '0; desc_valid = '0;
   endtask

   function automatic logic [DW-1:0] mk(input logic en, input logic [PW-1:0] p, input logic [CW-1:0] c);
      return {en, p, c};
   endfunction

   task automatic wr(input int a, input logic [DW-1:0] d);
      wr_en = 1; wr_addr = AW'(a); wr_data = d;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      rd_addr = AW'(a); #0.1; v = rd_data;
   endtask

   always @(posedge clk) begin
      cyc_n++;
      if (cyc_n > 100000) begin
         n_err++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] v;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      chk("R11 reset irq", 64'(irq), 0);
      chk("R8 reset latches", 64'(irq_vec), 0);
      rd(0, v); chk("R12 reset status read", 64'(v), 0);

      // unchained block of three words on channel 0
      wr(0, mk(1, '0, 16'd3)); cyc();
      rd(2, v); chk("R1 count loaded", 64'(v), 3);
      rd(0, v); chk("R1 active set", 64'(v[0]), 1);
      buf_strb[0] = 1; cyc(); buf_strb[0] = 1; cyc();
      rd(2, v); chk("R2 count after two strobes", 64'(v), 1);
      wr(0, mk(1, '0, 16'd9)); cyc();
      rd(2, v); chk("R10 busy write ignored", 64'(v), 1);
      buf_strb[0] = 1; cyc();
      chk("R3 latch on final word", 64'(irq_vec[0]), 1);
      rd(0, v); chk("R3 inactive after final", 64'(v[0]), 0);
      chk("R11 irq high", 64'(irq), 1);
      cyc(); cyc();
      chk("R8 sticky", 64'(irq_vec[0]), 1);
      wr(NCH, DW'(1)); cyc();
      chk("R8 cleared", 64'(irq_vec), 0);
      chk("R11 irq low", 64'(irq), 0);

      // idle strobe on channel 1 with a simultaneous clear
      buf_strb[1] = 1; wr(NCH, DW'(2)); cyc();
      chk("R7 R8 set wins over clear", 64'(irq_vec[1]), 1);
      wr(NCH, DW'(2)); cyc();
      chk("R8 clear channel 1", 64'(irq_vec[1]), 0);

      // zero count start on channel 2
      wr(2, mk(1, '0, 16'd0)); cyc();
      chk("R9 no latch yet", 64'(irq_vec[2]), 0);
      rd(0, v); chk("R9 active one cycle", 64'(v[2]), 1);
      cyc();
      chk("R9 latch next edge", 64'(irq_vec[2]), 1);
      rd(0, v); chk("R9 back to idle", 64'(v[2]), 0);
      wr(NCH, DW'(4)); cyc();

      // enable clear on channel 3
      wr(3, mk(0, '0, 16'd5)); cyc();
      rd(0, v); chk("R10 disabled write ignored", 64'(v), 0);
      rd(5, v); chk("R12 count read idle", 64'(v), 0);

      // chain on channel 3: flag set, then flag clear, then final
      wr(3, mk(1, FLAG | 20'h00010, 16'd1)); cyc();
      buf_strb[3] = 1; cyc();
      chk("R4 per-block latch", 64'(irq_vec[3]), 1);
      chk("R4 desc_req", 64'(desc_req[3]), 1);
      chk("R4 desc_addr", 64'(desc_addr[3*PW +: PW]), 64'h10);
      rd(0, v); chk("R4 still active", 64'(v[3]), 1);
      cyc(); cyc(); cyc();
      chk("R6 waiting", 64'(desc_req[3]), 1);
      rd(0, v); chk("R6 active while waiting", 64'(v[3]), 1);
      desc_valid[3] = 1; desc_count[3*CW +: CW] = 16'd2; desc_ptr[3*PW +: PW] = 20'h00020;
      wr(NCH, DW'(8)); cyc();
      rd(5, v); chk("R6 next count loaded", 64'(v), 2);
      chk("R6 request dropped", 64'(desc_req[3]), 0);
      buf_strb[3] = 1; cyc(); buf_strb[3] = 1; cyc();
      chk("R5 no latch mid chain", 64'(irq_vec[3]), 0);
      chk("R5 fetch after block", 64'(desc_req[3]), 1);
      desc_valid[3] = 1; desc_count[3*CW +: CW] = 16'd1; desc_ptr[3*PW +: PW] = '0; cyc();
      buf_strb[3] = 1; cyc();
      chk("R5 latch at chain end", 64'(irq_vec[3]), 1);
      rd(0, v); chk("R3 chain end idle", 64'(v[3]), 0);
      wr(NCH, DW'(8)); cyc();

      // random traffic checked against the model
      rd_addr = '0;
      for (int n = 0; n < 4000; n++) begin
         int r;
         for (int i = 0; i < NCH; i++) begin
            buf_strb[i] = ($urandom % 3) == 0;
            if (desc_req[i] && ($urandom % 2)) begin
               logic [PW-1:0] p;
               desc_valid[i] = 1;
               desc_count[i*CW +: CW] = CW'($urandom % 5);
               p = (($urandom % 2) != 0) ? FLAG : '0;
               if (($urandom % 3) != 0) p = p | PW'($urandom % 255 + 1);
               desc_ptr[i*PW +: PW] = p;
            end
         end
         r = $urandom % 10;
         if (r < 2) begin
            logic [PW-1:0] p;
            p = (($urandom % 2) != 0) ? FLAG : '0;
            if (($urandom % 2) != 0) p = p | PW'($urandom % 255 + 1);
            wr($urandom % NCH, mk(1'($urandom % 4 != 0), p, CW'($urandom % 7)));
         end else if (r == 2) begin
            wr(NCH, DW'($urandom % 16));
         end
         cyc();
      end

      summary();
      $finish;
   end
endmodule